// File: doc/BRIEF.md
# Floating-point control and sticky-status register

This block keeps the 64-bit control word of a floating-point unit together with six sticky exception flags. Software reaches both through one register port: a write strobe with a select bit picking control word or status word, and a combinational read port with its own select. From the control word the block drives the arithmetic unit's mode inputs: rounding direction, flush-to-zero, default-NaN and the alternate half-precision format. The flush output already accounts for whether the current operation is half precision.

Each cycle the arithmetic unit may pulse any mix of six exception events. An event whose trap enable is clear sets its sticky flag. An event whose trap enable is set leaves the flag alone. Instead, one cycle later, the block raises a trap request together with a vector naming every trapped exception. Two parameters fix what the hardware supports. `EXC_SUPPORT` says which exceptions may have a trap enable. `CTX_WRITABLE` says whether the stride and length context fields are stored or read as zero.

Top module: `fpctl_regs`

## Requirements
- R1: Control bits 63:27, 14:13 and 7:0 always read as zero, whatever is written. Status bits 63:6 always read as zero.
- R2: The control fields sit at these positions: bit 26 alternate half format (`ahp_o`), bit 25 default NaN (`dn_o`), bits 23:22 rounding (`rmode_o`: 00 nearest, 01 toward +inf, 10 toward -inf, 11 toward zero). Bit 24 is flush, bit 19 is half flush, bits 21:20 are stride and bits 18:16 are length. Each written field reads back and reaches its output after the write cycle.
- R3: `flush_o` follows bit 24 when `hp_op_i` is 0 and bit 19 when `hp_op_i` is 1. Neither bit affects the other case.
- R4: Exception index order is bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 input denormal. This order holds for `evt_i`, `trap_cause_o` and status bits 5:0. A pulse on an exception whose enable is 0 sets its status bit at the next edge. Events accumulate by OR.
- R5: Trap enables are at control bits 8 to 12 for indices 0 to 4, and at bit 15 for index 5. A pulse on an enabled exception leaves its status bit unchanged. For exactly one cycle after the event edge, it sets `trap_req_o` and the matching bit of `trap_cause_o`.
- R6: A trap enable whose bit in `EXC_SUPPORT` is 0 reads as zero and ignores writes, so that exception always goes to its status bit.
- R7: With `CTX_WRITABLE`=1, stride and length store and read back. With 0 they read as zero. In either case they change no mode output.
- R8: An input-denormal event while `hp_op_i` is 1 and bit 19 is 1 is discarded: it sets no status bit and raises no trap.
- R9: After reset, the control word, the status bits, `trap_req_o` and `trap_cause_o` are all zero.
- R10: A status bit clears only through a status write. When a status write and an event land in the same cycle, the event's set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 status word |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read source: 0 control word, 1 status word |
| rd_data_o | output | 64 | Read data, combinational |
| evt_i | input | 6 | Exception event pulses (R4 order) |
| hp_op_i | input | 1 | Current operation is half precision |
| rmode_o | output | 2 | Rounding mode |
| flush_o | output | 1 | Flush-to-zero for the current operation |
| dn_o | output | 1 | Default-NaN mode |
| ahp_o | output | 1 | Alternate half-precision format |
| trap_req_o | output | 1 | Trap request, one cycle |
| trap_cause_o | output | 6 | Exceptions that caused the trap |

## Verification
The event router is driven with events whose enables are clear, alone and in overlapping groups, which separates setting from accumulating. Mixed groups where only some enables are set show that trapped and untrapped exceptions are routed apart within the same cycle. A status write that coincides with an event pins down which of the two wins. The same all-ones control write and the same input-denormal event go to two instances with different support parameters, which tells masked enables apart from stored ones. Flush settings are swapped against `hp_op_i` to show that each precision reads only its own bit.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
  localparam int unsigned CW   = 64;
  localparam int unsigned NEXC = 6;

  typedef enum logic [2:0] {
    EXC_INV = 3'd0, EXC_DZ = 3'd1, EXC_OVF = 3'd2,
    EXC_UNF = 3'd3, EXC_INX = 3'd4, EXC_IDN = 3'd5
  } exc_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00, RM_PINF = 2'b01, RM_MINF = 2'b10, RM_ZERO = 2'b11
  } rmode_e;

  localparam int POS_AHP = 26;
  localparam int POS_DN  = 25;
  localparam int POS_FZ  = 24;
  localparam int POS_RM  = 22;
  localparam int POS_STR = 20;
  localparam int POS_FZH = 19;
  localparam int POS_LEN = 16;

  typedef struct packed {
    rmode_e rmode;
    logic   fz;
    logic   fzh;
    logic   dn;
    logic   ahp;
  } mode_t;

  // control-word bit holding the trap enable of exception i
  function automatic int en_pos(int i);
    return (i == int'(EXC_IDN)) ? 15 : 8 + i;
  endfunction

  function automatic logic [CW-1:0] ctrl_wmask(logic [NEXC-1:0] sup, bit ctx);
    logic [CW-1:0] m;
    m = '0;
    m[POS_AHP] = 1'b1;
    m[POS_DN]  = 1'b1;
    m[POS_FZ]  = 1'b1;
    m[POS_RM+:2] = 2'b11;
    m[POS_FZH] = 1'b1;
    if (ctx) begin
      m[POS_STR+:2] = 2'b11;
      m[POS_LEN+:3] = 3'b111;
    end
    for (int i = 0; i < int'(NEXC); i++) m[en_pos(i)] = sup[i];
    return m;
  endfunction
endpackage

// File: rtl/fpctl_ctrl_reg.sv
module fpctl_ctrl_reg #(
  parameter int unsigned         W     = 64,
  parameter logic [W-1:0]        WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i & WMASK;
  end
endmodule

// File: rtl/fpctl_mode_dec.sv
module fpctl_mode_dec
  import fpctl_pkg::*;
(
  input  logic [CW-1:0] ctrl_i,
  input  logic          hp_op_i,
  output mode_t         mode_o,
  output logic          flush_o,
  output logic          idn_drop_o
);
  always_comb begin
    mode_o.rmode = rmode_e'(ctrl_i[POS_RM+:2]);
    mode_o.fz    = ctrl_i[POS_FZ];
    mode_o.fzh   = ctrl_i[POS_FZH];
    mode_o.dn    = ctrl_i[POS_DN];
    mode_o.ahp   = ctrl_i[POS_AHP];
  end

  // half-precision ops see only their own flush bit
  assign flush_o    = hp_op_i ? ctrl_i[POS_FZH] : ctrl_i[POS_FZ];
  // a half input flushed by fzh must not report input denormal
  assign idn_drop_o = hp_op_i & ctrl_i[POS_FZH];
endmodule

// File: rtl/fpctl_exc_route.sv
module fpctl_exc_route #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic         st_we_i,
  input  logic [N-1:0] st_wdata_i,
  output logic [N-1:0] sticky_o,
  output logic         trap_req_o,
  output logic [N-1:0] trap_cause_o
);
  logic [N-1:0] hit_trap;

  for (genvar i = 0; i < N; i++) begin : g_exc
    logic set_st;
    assign set_st      = evt_i[i] & ~en_i[i];
    assign hit_trap[i] = evt_i[i] &  en_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sticky_o[i] <= 1'b0;
      else if (set_st)   sticky_o[i] <= 1'b1;         // event beats write
      else if (st_we_i)  sticky_o[i] <= st_wdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_cause_o <= '0;
      trap_req_o   <= 1'b0;
    end else begin
      trap_cause_o <= hit_trap;
      trap_req_o   <= |hit_trap;
    end
  end
endmodule

// File: rtl/fpctl_regs.sv
module fpctl_regs
  import fpctl_pkg::*;
#(
  parameter logic [5:0] EXC_SUPPORT  = 6'b011111,
  parameter bit         CTX_WRITABLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [63:0]   wr_data_i,
  input  logic          rd_sel_i,
  output logic [63:0]   rd_data_o,
  input  logic [5:0]    evt_i,
  input  logic          hp_op_i,
  output logic [1:0]    rmode_o,
  output logic          flush_o,
  output logic          dn_o,
  output logic          ahp_o,
  output logic          trap_req_o,
  output logic [5:0]    trap_cause_o
);
  localparam logic [CW-1:0] WMASK = ctrl_wmask(EXC_SUPPORT, CTX_WRITABLE);

  logic [CW-1:0]   ctrl_q;
  logic [NEXC-1:0] sticky_q;
  logic [NEXC-1:0] en_vec;
  logic [NEXC-1:0] evt_q;
  mode_t           mode;
  logic            idn_drop;

  fpctl_ctrl_reg #(.W(CW), .WMASK(WMASK)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i & ~wr_sel_i),
    .wdata_i (wr_data_i),
    .q_o     (ctrl_q)
  );

  fpctl_mode_dec u_dec (
    .ctrl_i     (ctrl_q),
    .hp_op_i    (hp_op_i),
    .mode_o     (mode),
    .flush_o    (flush_o),
    .idn_drop_o (idn_drop)
  );

  for (genvar i = 0; i < NEXC; i++) begin : g_en
    localparam int P = en_pos(i);
    assign en_vec[i] = ctrl_q[P];
    if (i == int'(EXC_IDN)) begin : g_idn
      assign evt_q[i] = evt_i[i] & ~idn_drop;
    end else begin : g_oth
      assign evt_q[i] = evt_i[i];
    end
  end

  fpctl_exc_route #(.N(NEXC)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_q),
    .en_i         (en_vec),
    .st_we_i      (wr_en_i & wr_sel_i),
    .st_wdata_i   (wr_data_i[NEXC-1:0]),
    .sticky_o     (sticky_q),
    .trap_req_o   (trap_req_o),
    .trap_cause_o (trap_cause_o)
  );

  assign rmode_o   = mode.rmode;
  assign dn_o      = mode.dn;
  assign ahp_o     = mode.ahp;
  assign rd_data_o = rd_sel_i ? {{(CW-NEXC){1'b0}}, sticky_q} : ctrl_q;
endmodule

// File: rtl/fpctl_regs_chk.sv
module fpctl_regs_chk
  import fpctl_pkg::*;
#(
  parameter logic [5:0] EXC_SUPPORT = 6'b011111
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [5:0]  evt_i,
  input logic        hp_op_i,
  input logic [63:0] ctrl_q,
  input logic [5:0]  sticky_q,
  input logic        rd_sel_i,
  input logic [63:0] rd_data_o,
  input logic        trap_req_o,
  input logic [5:0]  trap_cause_o
);
  p_resv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> (rd_data_o[63:27] == '0 && rd_data_o[14:13] == '0 && rd_data_o[7:0] == '0));

  p_hp_idn_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_op_i && ctrl_q[POS_FZH] && !sticky_q[5] && !(wr_en_i && wr_sel_i)) |=> !sticky_q[5]);

  for (genvar k = 0; k < 6; k++) begin : g_k
    localparam int P = en_pos(k);

    if (k == 5) begin : g_st5
      p_sticky_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[k] && !ctrl_q[P] && !(hp_op_i && ctrl_q[POS_FZH])) |=> sticky_q[k]);
    end else begin : g_st
      p_sticky_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[k] && !ctrl_q[P]) |=> sticky_q[k]);
    end

    if (k == 5) begin : g_tr5
      p_trap_raise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[k] && ctrl_q[P] && !(hp_op_i && ctrl_q[POS_FZH])) |=> (trap_req_o && trap_cause_o[k]));
    end else begin : g_tr
      p_trap_raise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[k] && ctrl_q[P]) |=> (trap_req_o && trap_cause_o[k]));
    end

    p_trap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[P] && !(wr_en_i && wr_sel_i)) |=> $stable(sticky_q[k]));

    if (!EXC_SUPPORT[k]) begin : g_uns
      p_unsup_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_q[P]);
    end
  end
endmodule

bind fpctl_regs fpctl_regs_chk #(.EXC_SUPPORT(EXC_SUPPORT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .evt_i        (evt_i),
  .hp_op_i      (hp_op_i),
  .ctrl_q       (ctrl_q),
  .sticky_q     (sticky_q),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .trap_req_o   (trap_req_o),
  .trap_cause_o (trap_cause_o)
);

// File: tb/fpctl_regs_tb_top.sv
`timescale 1ns/1ps
module fpctl_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0, hp_op_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [5:0]  evt_i = '0;

  logic [63:0] rd_a, rd_b;
  logic [1:0]  rm_a, rm_b;
  logic        fl_a, fl_b, dn_a, dn_b, ahp_a, ahp_b, tr_a, tr_b;
  logic [5:0]  tc_a, tc_b;

  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  fpctl_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_a), .evt_i(evt_i),
    .hp_op_i(hp_op_i), .rmode_o(rm_a), .flush_o(fl_a), .dn_o(dn_a), .ahp_o(ahp_a),
    .trap_req_o(tr_a), .trap_cause_o(tc_a));

  fpctl_regs #(.EXC_SUPPORT(6'b111111), .CTX_WRITABLE(1'b0)) dut_raz_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_b), .evt_i(evt_i),
    .hp_op_i(hp_op_i), .rmode_o(rm_b), .flush_o(fl_b), .dn_o(dn_b), .ahp_o(ahp_b),
    .trap_req_o(tr_b), .trap_cause_o(tc_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] a, output logic [63:0] b);
    rd_sel_i = sel;
    #0.5;
    a = rd_a; b = rd_b;
  endtask

  task automatic pulse(input logic [5:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [63:0] a, b;
    rd(1'b0, a, b);
    chk("R9 ctrl", a, 64'h0);
    rd(1'b1, a, b);
    chk("R9 status", a, 64'h0);
    chk("R9 trap", {tr_a, tc_a}, 7'h0);
  endtask

  task automatic t_mask();
    logic [63:0] a, b;
    wr(1'b0, '1);
    rd(1'b0, a, b);
    chk("R1 R6 R7 ctrl ones, default inst", a, 64'h0000_0000_07FF_1F00);
    chk("R1 R6 R7 ctrl ones, raz inst", b, 64'h0000_0000_07C8_9F00);
    wr(1'b1, '1);
    rd(1'b1, a, b);
    chk("R1 status ones", a, 64'h3F);
    wr(1'b1, '0);
    wr(1'b0, '0);
  endtask

  task automatic t_modes();
    logic [63:0] a, b;
    for (int m = 0; m < 4; m++) begin
      wr(1'b0, 64'(m) << 22);
      chk("R2 rmode", {62'h0, rm_a}, 64'(m));
    end
    wr(1'b0, 64'h0600_0000);
    chk("R2 dn ahp", {dn_a, ahp_a, rm_a}, 4'b1100);
    rd(1'b0, a, b);
    chk("R2 readback", a, 64'h0600_0000);
    // context fields alone: stored, no mode effect
    wr(1'b0, 64'h0037_0000);
    rd(1'b0, a, b);
    chk("R7 ctx readback", a, 64'h0037_0000);
    chk("R7 ctx raz", b, 64'h0);
    hp_op_i = 1'b0; #0.5;
    chk("R7 no mode effect", {rm_a, fl_a, dn_a, ahp_a}, 5'h0);
    hp_op_i = 1'b1; #0.5;
    chk("R7 no mode effect hp", {rm_a, fl_a, dn_a, ahp_a}, 5'h0);
    hp_op_i = 1'b0;
    wr(1'b0, '0);
  endtask

  task automatic t_flush();
    wr(1'b0, 64'h0100_0000);
    hp_op_i = 1'b0; #0.5;
    chk("R3 fz on, single", fl_a, 1);
    hp_op_i = 1'b1; #0.5;
    chk("R3 fz on, half", fl_a, 0);
    wr(1'b0, 64'h0008_0000);
    chk("R3 fzh on, half", fl_a, 1);
    hp_op_i = 1'b0; #0.5;
    chk("R3 fzh on, single", fl_a, 0);
    wr(1'b0, '0);
  endtask

  task automatic t_sticky();
    logic [63:0] a, b;
    pulse(6'b000101);
    rd(1'b1, a, b);
    chk("R4 sticky set", a, 64'h05);
    chk("R4 no trap", {tr_a, tc_a}, 7'h0);
    pulse(6'b000010);
    rd(1'b1, a, b);
    chk("R4 sticky accumulate", a, 64'h07);
    tick(); tick();
    rd(1'b1, a, b);
    chk("R10 sticky holds", a, 64'h07);
    wr(1'b1, 64'h0);
    rd(1'b1, a, b);
    chk("R10 cleared by write", a, 64'h0);
  endtask

  task automatic t_trap();
    logic [63:0] a, b;
    wr(1'b0, 64'h0400);               // overflow enable
    pulse(6'b000100);
    chk("R5 trap req", {tr_a, tc_a}, {1'b1, 6'b000100});
    rd(1'b1, a, b);
    chk("R5 sticky untouched", a, 64'h0);
    tick();
    chk("R5 trap one cycle", {tr_a, tc_a}, 7'h0);
    pulse(6'b000101);
    chk("R5 mixed trap", {tr_a, tc_a}, {1'b1, 6'b000100});
    rd(1'b1, a, b);
    chk("R5 mixed sticky", a, 64'h01);
    wr(1'b1, '0);
    wr(1'b0, '0);
  endtask

  task automatic t_coincide();
    logic [63:0] a, b;
    wr(1'b1, 64'h3F);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = '0; evt_i = 6'b010000;
    tick();
    wr_en_i = 1'b0; evt_i = '0;
    rd(1'b1, a, b);
    chk("R10 event beats write", a, 64'h10);
    wr(1'b1, '0);
  endtask

  task automatic t_idn();
    logic [63:0] a, b;
    wr(1'b0, 64'h0008_8000);          // fzh + idn enable (raz inst only)
    hp_op_i = 1'b1;
    pulse(6'b100000);
    chk("R8 dropped, no trap", {tr_b, tc_b}, 7'h0);
    rd(1'b1, a, b);
    chk("R8 dropped, no sticky", a, 64'h0);
    hp_op_i = 1'b0;
    pulse(6'b100000);
    chk("R6 idn trap on supported", {tr_b, tc_b}, {1'b1, 6'b100000});
    chk("R6 no trap on unsupported", {tr_a, tc_a}, 7'h0);
    rd(1'b1, a, b);
    chk("R6 unsupported goes sticky", a, 64'h20);
    chk("R6 supported keeps sticky", b, 64'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_mask();
    t_modes();
    t_flush();
    t_sticky();
    t_trap();
    t_coincide();
    t_idn();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule